// File: doc/BRIEF.md
# GPIO Bank with Interrupt Controller

This block is a bank of general-purpose pins behind a small 32-bit register bus. Software selects per pin whether the output driver is on, and reads the synchronised level of every pin. Output values change only through two write-one registers: one raises pins and one lowers them. A build-time strap inverts the meaning of the direction register, so the same software view can match either driver convention.

Each pin also feeds an interrupt unit. Per-pin bits select edge or level sensitivity, the active polarity, whether the pin may raise a pending condition (enable), and whether that condition reaches the single interrupt line (mask). Edge conditions are held until software clears them by writing ones to the pending register. Level conditions follow the live input. There is no mode that fires on both edges. Software gets that behaviour by flipping a pin's polarity bit after each edge.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all zero for both strap settings), the output latch is zero, the enable, type, polarity, mask and pending registers read zero, and `irq` is low.
- R2: With `OE_INVERT`=0 a 1 in the direction register (offset 0x00) turns on that pin's driver. With `OE_INVERT`=1 a 1 makes the pin an input, so `pin_oe` is the inverse of the register.
- R3: Writing offset 0x0C sets to 1 the output latch bit of every pin whose data bit is 1 and leaves the others unchanged. Reading 0x0C returns the latch, which drives `pin_out`.
- R4: Writing offset 0x10 clears to 0 the output latch bit of every pin whose data bit is 1 and leaves the others unchanged.
- R5: Reading offset 0x04 returns `pin_in` after a two-flop synchroniser, so a change is visible no later than the third rising edge.
- R6: A pin with type bit 0 (offset 0x18) is edge sensitive. Polarity bit 1 (offset 0x1C) detects rising edges and polarity bit 0 detects falling edges. A detected edge latches the pin's bit in the pending register (offset 0x20).
- R7: A latched edge-pending bit stays set until software writes 1 to that bit at offset 0x20. A 0 in the written data leaves the bit set.
- R8: A pin with type bit 1 is level sensitive. Its pending bit reads 1 exactly while the synchronised input equals its polarity bit.
- R9: `irq` is a registered OR, over all pins, of pending AND enable (offset 0x14) AND mask (offset 0x24). A pin whose mask bit is 0 still shows its pending bit but does not raise `irq`.
- R10: A pin whose enable bit is 0 latches no edge and reports no level condition, and it shows no stale condition after it is enabled.
- R11: Changing an edge pin's polarity bit after an edge makes the next edge in the opposite direction latch pending again. This is how software detects both edges.
- R12: The direction, enable, type, polarity and mask registers read back as written, and bits at or above `NUM_PINS` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the register at `bus_addr` (combinational) |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output latch |
| pin_oe | output | NUM_PINS | Output driver enable, 1 = driving |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The hardest case to reach from the ports is software-emulated both-edge detection. The bench has to latch a rising edge, clear it, rewrite the polarity while the input is steady, and then show that only the following falling edge sets the pending bit again. The bench sequences these steps with waits long enough to cover the synchroniser and the edge register. A second hard case is a disabled pin that toggles and is then enabled. The bench checks that no stale pending bit appears once the enable is set.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BUS_DW = 32;
    localparam int BUS_AW = 8;

    typedef enum logic [BUS_AW-1:0] {
        OFS_DIR   = 8'h00,
        OFS_LEVEL = 8'h04,
        OFS_SET   = 8'h0C,
        OFS_CLR   = 8'h10,
        OFS_IEN   = 8'h14,
        OFS_ITYPE = 8'h18,
        OFS_IPOL  = 8'h1C,
        OFS_IPEND = 8'h20,
        OFS_IMASK = 8'h24
    } reg_ofs_e;

    typedef struct packed {
        logic dir;
        logic set;
        logic clr;
        logic ien;
        logic itype;
        logic ipol;
        logic ipend;
        logic imask;
    } wr_sel_t;

    function automatic wr_sel_t decode_write(input logic we, input logic [BUS_AW-1:0] a);
        wr_sel_t s;
        s.dir   = we && (a == OFS_DIR);
        s.set   = we && (a == OFS_SET);
        s.clr   = we && (a == OFS_CLR);
        s.ien   = we && (a == OFS_IEN);
        s.itype = we && (a == OFS_ITYPE);
        s.ipol  = we && (a == OFS_IPOL);
        s.ipend = we && (a == OFS_IPEND);
        s.imask = we && (a == OFS_IMASK);
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS  = 16,
    parameter bit OE_INVERT = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  wr_sel_t             sel,
    input  logic [NUM_PINS-1:0] wd,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] out_q,
    output logic [NUM_PINS-1:0] ien_q,
    output logic [NUM_PINS-1:0] itype_q,
    output logic [NUM_PINS-1:0] ipol_q,
    output logic [NUM_PINS-1:0] imask_q,
    output logic [NUM_PINS-1:0] oe
);
    localparam logic [NUM_PINS-1:0] DIR_RST = OE_INVERT ? '1 : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= DIR_RST;
            out_q   <= '0;
            ien_q   <= '0;
            itype_q <= '0;
            ipol_q  <= '0;
            imask_q <= '0;
        end else begin
            if (sel.dir)   dir_q   <= wd;
            if (sel.set)   out_q   <= out_q | wd;
            if (sel.clr)   out_q   <= out_q & ~wd;
            if (sel.ien)   ien_q   <= wd;
            if (sel.itype) itype_q <= wd;
            if (sel.ipol)  ipol_q  <= wd;
            if (sel.imask) imask_q <= wd;
        end
    end

    generate
        if (OE_INVERT) begin : g_oe_inv
            assign oe = ~dir_q;
        end else begin : g_oe_direct
            assign oe = dir_q;
        end
    endgenerate
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] lvl,
    input  logic [NUM_PINS-1:0] ien,
    input  logic [NUM_PINS-1:0] itype,
    input  logic [NUM_PINS-1:0] ipol,
    input  logic [NUM_PINS-1:0] imask,
    input  logic                ack_we,
    input  logic [NUM_PINS-1:0] ack_bits,
    output logic [NUM_PINS-1:0] pend,
    output logic [NUM_PINS-1:0] edge_pend,
    output logic                irq
);
    logic [NUM_PINS-1:0] lvl_prev;
    logic [NUM_PINS-1:0] edge_hit;
    logic [NUM_PINS-1:0] lvl_hit;
    logic [NUM_PINS-1:0] ack;

    assign ack = ack_we ? ack_bits : '0;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        // polarity 1: low->high, polarity 0: high->low
        assign edge_hit[i] = ien[i] && !itype[i] &&
                             (lvl[i] == ipol[i]) && (lvl_prev[i] != ipol[i]);
        assign lvl_hit[i]  = ien[i] && itype[i] && (lvl[i] == ipol[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_prev  <= '0;
            edge_pend <= '0;
            irq       <= 1'b0;
        end else begin
            lvl_prev  <= lvl;
            edge_pend <= (edge_pend & ~ack) | edge_hit;
            irq       <= |(pend & ien & imask);
        end
    end

    assign pend = (edge_pend & ~itype) | lvl_hit;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS  = 16,
    parameter bit OE_INVERT = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_we,
    input  logic [7:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int PAD = BUS_DW - NUM_PINS;

    wr_sel_t             sel;
    logic [NUM_PINS-1:0] wd;
    logic [NUM_PINS-1:0] lvl;
    logic [NUM_PINS-1:0] dir_q, out_q, ien_q, itype_q, ipol_q, imask_q;
    logic [NUM_PINS-1:0] pend, edge_pend;

    assign sel = decode_write(bus_we, bus_addr);
    assign wd  = bus_wdata[NUM_PINS-1:0];

    gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (lvl)
    );

    gpio_regfile #(.NUM_PINS(NUM_PINS), .OE_INVERT(OE_INVERT)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .wd      (wd),
        .dir_q   (dir_q),
        .out_q   (out_q),
        .ien_q   (ien_q),
        .itype_q (itype_q),
        .ipol_q  (ipol_q),
        .imask_q (imask_q),
        .oe      (pin_oe)
    );

    gpio_irq_unit #(.NUM_PINS(NUM_PINS)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .lvl       (lvl),
        .ien       (ien_q),
        .itype     (itype_q),
        .ipol      (ipol_q),
        .imask     (imask_q),
        .ack_we    (sel.ipend),
        .ack_bits  (wd),
        .pend      (pend),
        .edge_pend (edge_pend),
        .irq       (irq)
    );

    assign pin_out = out_q;

    logic [NUM_PINS-1:0] rd_sel;
    always_comb begin
        case (bus_addr)
            OFS_DIR:   rd_sel = dir_q;
            OFS_LEVEL: rd_sel = lvl;
            OFS_SET:   rd_sel = out_q;
            OFS_IEN:   rd_sel = ien_q;
            OFS_ITYPE: rd_sel = itype_q;
            OFS_IPOL:  rd_sel = ipol_q;
            OFS_IPEND: rd_sel = pend;
            OFS_IMASK: rd_sel = imask_q;
            default:   rd_sel = '0;
        endcase
    end

    assign bus_rdata = {{PAD{1'b0}}, rd_sel};
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int NUM_PINS = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_we,
    input logic [7:0]          bus_addr,
    input logic [31:0]         bus_wdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                irq,
    input logic [NUM_PINS-1:0] edge_pend,
    input logic [NUM_PINS-1:0] ien_q,
    input logic [NUM_PINS-1:0] imask_q
);
    AST_RESET_INPUTS: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && pin_out == '0 && !irq)); // R1

    AST_SET_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 8'h0C) |=>
            ((pin_out & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0]))); // R3

    AST_CLR_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 8'h10) |=>
            ((pin_out & $past(bus_wdata[NUM_PINS-1:0])) == '0)); // R4

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> $stable(pin_out)); // R3

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == 8'h20) |=>
            ((edge_pend & $past(edge_pend)) == $past(edge_pend))); // R7

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(ien_q & imask_q) != '0)); // R9
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .edge_pend (edge_pend),
    .ien_q     (ien_q),
    .imask_q   (imask_q)
);

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
module gpio_bank_bench;
    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          we  = 1'b0;
    logic          we2 = 1'b0;
    logic [7:0]    addr = 8'h00;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata, rdata2;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out, pin_oe, pin_out2, pin_oe2;
    logic          irq, irq2;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    gpio_bank #(.NUM_PINS(N), .OE_INVERT(1'b0)) u_gpio_bank (
        .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    gpio_bank #(.NUM_PINS(N), .OE_INVERT(1'b1)) u_gpio_bank_inv (
        .clk(clk), .rst(rst), .bus_we(we2), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata2), .pin_in(pin_in), .pin_out(pin_out2), .pin_oe(pin_oe2), .irq(irq2)
    );

    typedef struct packed {
        logic [7:0]  wa;
        logic [31:0] wd;
        logic [7:0]  ra;
        logic [31:0] exp;
        int          req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{8'h00, 32'hFFFF_FFFF, 8'h00, 32'h0000_FFFF, 12}, // R12 upper bits read zero
        '{8'h00, 32'h0000_0005, 8'h00, 32'h0000_0005, 2},  // R2 direction readback
        '{8'h0C, 32'h0000_F0F0, 8'h0C, 32'h0000_F0F0, 3},  // R3 set
        '{8'h0C, 32'h0000_000F, 8'h0C, 32'h0000_F0FF, 3},  // R3 zeros keep
        '{8'h10, 32'h0000_0033, 8'h0C, 32'h0000_F0CC, 4},  // R4 clear
        '{8'h10, 32'h0000_0000, 8'h0C, 32'h0000_F0CC, 4},  // R4 zeros keep
        '{8'h14, 32'h0000_AAAA, 8'h14, 32'h0000_AAAA, 12}, // R12 enable
        '{8'h18, 32'h0000_1234, 8'h18, 32'h0000_1234, 12}, // R12 type
        '{8'h1C, 32'h0000_8001, 8'h1C, 32'h0000_8001, 12}, // R12 polarity
        '{8'h24, 32'h0000_00FF, 8'h24, 32'h0000_00FF, 12}, // R12 mask
        '{8'h14, 32'h0000_0000, 8'h14, 32'h0000_0000, 12},
        '{8'h18, 32'h0000_0000, 8'h18, 32'h0000_0000, 12},
        '{8'h24, 32'h0000_0000, 8'h24, 32'h0000_0000, 12}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit second = 1'b0);
        @(negedge clk);
        addr  = a;
        wdata = d;
        if (second) we2 = 1'b1; else we = 1'b1;
        @(negedge clk);
        we  = 1'b0;
        we2 = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        idle(3);
        // R1 reset state
        check("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
        check("R1 pin_oe inverted strap", {16'h0, pin_oe2}, 32'h0);
        check("R1 pin_out", {16'h0, pin_out}, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        rst = 1'b0;
        rd(8'h14, v); check("R1 enable", v, 32'h0);
        rd(8'h18, v); check("R1 type", v, 32'h0);
        rd(8'h1C, v); check("R1 polarity", v, 32'h0);
        rd(8'h20, v); check("R1 pending", v, 32'h0);
        rd(8'h24, v); check("R1 mask", v, 32'h0);

        for (int i = 0; i < NV; i++) begin
            wr(TBL[i].wa, TBL[i].wd);
            rd(TBL[i].ra, v);
            check($sformatf("R%0d table row %0d", TBL[i].req, i), v, TBL[i].exp);
        end
        check("R3 pin_out", {16'h0, pin_out}, 32'h0000_F0CC);

        // R2 both strap settings
        check("R2 pin_oe direct", {16'h0, pin_oe}, 32'h0000_0005);
        wr(8'h00, 32'h0000_0001, 1'b1);
        check("R2 pin_oe inverted", {16'h0, pin_oe2}, 32'h0000_FFFE);

        // R5 synchronised input level
        @(negedge clk); pin_in = 16'hA5C3;
        rd(8'h04, v); check("R5 not yet visible", v, 32'h0);
        idle(2);
        rd(8'h04, v); check("R5 level", v, 32'h0000_A5C3);
        @(negedge clk); pin_in = '0;
        idle(4);

        // pin0 rising edge, pin1 falling edge, pin2 level high, pin3 disabled
        wr(8'h1C, 32'h0000_0005);
        wr(8'h18, 32'h0000_0004);
        wr(8'h14, 32'h0000_0007);
        wr(8'h24, 32'h0000_0003);
        idle(4);
        rd(8'h20, v); check("R8 level inactive", v, 32'h0);
        check("R9 irq quiet", {31'h0, irq}, 32'h0);

        // R6 rising edge latch
        @(negedge clk); pin_in[0] = 1'b1;
        idle(6);
        rd(8'h20, v); check("R6 rising latched", v, 32'h1);
        check("R9 irq from edge", {31'h0, irq}, 32'h1);
        // R7 zeros in ack leave bit set
        wr(8'h20, 32'h0000_0002);
        idle(3);
        rd(8'h20, v); check("R7 zero ack keeps", v, 32'h1);
        wr(8'h20, 32'h0000_0001);
        idle(3);
        rd(8'h20, v); check("R7 ack clears", v, 32'h0);
        check("R7 irq drops", {31'h0, irq}, 32'h0);

        // R11 flip polarity, next falling edge detected
        wr(8'h1C, 32'h0000_0004);
        idle(4);
        rd(8'h20, v); check("R11 no spurious on flip", v, 32'h0);
        @(negedge clk); pin_in[0] = 1'b0;
        idle(6);
        rd(8'h20, v); check("R11 opposite edge", v, 32'h1);
        wr(8'h20, 32'h0000_0001);

        // R6 falling polarity ignores rising
        @(negedge clk); pin_in[1] = 1'b1;
        idle(6);
        rd(8'h20, v); check("R6 rise ignored at pol 0", v, 32'h0);
        @(negedge clk); pin_in[1] = 1'b0;
        idle(6);
        rd(8'h20, v); check("R6 falling latched", v, 32'h2);
        wr(8'h20, 32'h0000_0002);
        idle(3);

        // R8 / R9 level with mask
        @(negedge clk); pin_in[2] = 1'b1;
        idle(5);
        rd(8'h20, v); check("R8 level high pending", v, 32'h4);
        check("R9 masked no irq", {31'h0, irq}, 32'h0);
        wr(8'h24, 32'h0000_0007);
        idle(2);
        check("R9 unmasked irq", {31'h0, irq}, 32'h1);
        @(negedge clk); pin_in[2] = 1'b0;
        idle(5);
        rd(8'h20, v); check("R8 level follows low", v, 32'h0);
        check("R8 irq drops", {31'h0, irq}, 32'h0);
        wr(8'h1C, 32'h0000_0000);
        idle(2);
        rd(8'h20, v); check("R8 active low level", v, 32'h4);
        wr(8'h1C, 32'h0000_0004);
        idle(3);

        // R10 disabled pin3, falling edge type
        @(negedge clk); pin_in[3] = 1'b1;
        idle(5);
        @(negedge clk); pin_in[3] = 1'b0;
        idle(6);
        rd(8'h20, v); check("R10 disabled no pend", v, 32'h0);
        check("R10 disabled no irq", {31'h0, irq}, 32'h0);
        wr(8'h14, 32'h0000_000F);
        idle(3);
        rd(8'h20, v); check("R10 no stale after enable", v, 32'h0);

        done = 1'b1;
        finish_run();
    end
endmodule